// File: doc/BRIEF.md
# Binary/BCD Time-Calendar Update Engine

This block holds the seven timekeeping bytes of a real-time clock: seconds, minutes, hours, day of week, date, month and two-digit year. Each pulse on the tick input, normally once per second, advances the whole set by one second. Carries run through to the day, month and year, and February follows a leap rule that is valid for a hundred-year span. One mode input selects plain binary or packed BCD storage for every byte. A second mode input selects a 24-hour clock, or a 12-hour clock that keeps an afternoon flag in the top bit of the hours byte.

Software loads the bytes through a single-byte write port and observes them through a combinational read port. It raises the hold input while loading so that no update interleaves with its writes. The block never converts stored bytes. After a change of either mode, the affected bytes must be rewritten. Each accepted update is followed by a one-clock done pulse, which interrupt logic can consume.

Top module: `rtc_time_engine`

## Requirements
- R1: After synchronous reset the bytes read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00, and the done output is 0.
- R2: With bin_mode=1, each byte holds its value as a plain binary number. A tick at a clock edge with hold low advances seconds, which wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. In 24-hour mode, hours wrap 23→0.
- R3: With bin_mode=0, each byte holds two packed BCD digits (tens in bits 7:4, units in bits 3:0), so for example 09 steps to 0x10 and 0x59 wraps to 0x00.
- R4: With hr24=0, bit 7 of the hours byte is the afternoon flag and bits 6:0 hold 12, 1..11 in the selected encoding. Stepping 11→12 toggles the flag, 12 steps to 1, and 11 pm wraps to 12 am with a day carry.
- R5: Day of week counts 1..7. It advances when the hours wrap at midnight, and 7 is followed by 1.
- R6: Months 4, 6, 9 and 11 have 30 days, and the other months have 31 except month 2. Month 2 has 29 days when the year is divisible by 4, otherwise 28. After the last day, the date returns to 1 and the month advances.
- R7: Month 12 is followed by month 1 with a year carry, and year 99 is followed by year 00.
- R8: While set_hold=1, ticks do not change any byte and produce no done pulse.
- R9: wr_sel and rd_sel index the bytes as 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. A write lands at the next edge. rd_data follows rd_sel combinationally. Index 7 reads 0x00, and a write to it changes nothing.
- R10: upd_done is high for exactly the one cycle after each edge at which a tick was accepted, and the new bytes are readable in that same cycle.
- R11: A write in the same cycle as a tick takes priority. The written byte lands, the tick is dropped, and no done pulse follows.
- R12: Changing bin_mode or hr24 leaves every stored byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second update request |
| set_hold | input | 1 | Freezes updates while 1 |
| bin_mode | input | 1 | 1 binary, 0 packed BCD |
| hr24 | input | 1 | 1 24-hour, 0 12-hour with PM flag |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 3 | Byte index for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Byte index for reads |
| rd_data | output | 8 | Selected byte |
| upd_done | output | 1 | One-clock pulse after each update |

## Verification
A corrupted byte, or a wrong carry decision, shows up on rd_data in the cycle right after the faulty update, because every update rewrites all seven bytes at one edge. The bench therefore reads back every byte after each tick. It compares them with a bench model loaded from random valid times that are biased toward rollover, and adds directed month-end, leap-year, midnight, noon and century cases. A faulty hold, write priority or done path shows up as a missing or extra pulse on upd_done, or as a byte that moved, in that same cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int FW    = 8;
    localparam int NF    = 7;
    localparam int SEL_W = 3;

    typedef logic [FW-1:0]         fld_t;
    typedef logic [NF-1:0][FW-1:0] fld_vec_t;

    typedef enum logic [SEL_W-1:0] {
        F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_DOW = 3'd3,
        F_DATE = 3'd4, F_MON = 3'd5, F_YEAR = 3'd6
    } fld_idx_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [4:0] hour;
        logic [2:0] dow;
        logic [4:0] date;
        logic [3:0] mon;
        logic [6:0] year;
    } tm_bin_t;

    localparam fld_vec_t RESET_VAL = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    function automatic logic [6:0] bcd_to_bin(input fld_t b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic fld_t bin_to_bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] year);
        case (mon)
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            4'd2:                    return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            default:                 return 5'd31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
    import rtc_cal_pkg::*;
(
    input  fld_vec_t raw,
    input  logic     bin_mode,
    input  logic     hr24,
    output tm_bin_t  t
);
    logic [NF-1:0][6:0] val;

    for (genvar i = 0; i < NF; i++) begin : g_dec
        fld_t masked;
        if (i == int'(F_HOUR)) begin : g_hr
            assign masked = hr24 ? raw[i] : {1'b0, raw[i][6:0]};
        end else begin : g_oth
            assign masked = raw[i];
        end
        assign val[i] = bin_mode ? masked[6:0] : bcd_to_bin(masked);
    end

    logic [6:0] h12_base;
    logic [6:0] hour_full;
    always_comb begin
        h12_base  = (val[F_HOUR] == 7'd12) ? 7'd0 : val[F_HOUR];
        hour_full = hr24 ? val[F_HOUR] : (h12_base + (raw[F_HOUR][7] ? 7'd12 : 7'd0));
        t.sec  = val[F_SEC];
        t.min  = val[F_MIN];
        t.hour = 5'(hour_full);
        t.dow  = 3'(val[F_DOW]);
        t.date = 5'(val[F_DATE]);
        t.mon  = 4'(val[F_MON]);
        t.year = val[F_YEAR];
    end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_cal_pkg::*;
(
    input  tm_bin_t cur,
    output tm_bin_t nxt
);
    always_comb begin
        logic day_roll;
        nxt      = cur;
        day_roll = 1'b0;
        if (cur.sec == 7'd59) begin
            nxt.sec = 7'd0;
            if (cur.min == 7'd59) begin
                nxt.min = 7'd0;
                if (cur.hour == 5'd23) begin
                    nxt.hour = 5'd0;
                    day_roll = 1'b1;
                end else begin
                    nxt.hour = cur.hour + 5'd1;
                end
            end else begin
                nxt.min = cur.min + 7'd1;
            end
        end else begin
            nxt.sec = cur.sec + 7'd1;
        end

        if (day_roll) begin
            nxt.dow = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
            if (cur.date >= month_len(cur.mon, cur.year)) begin
                nxt.date = 5'd1;
                if (cur.mon == 4'd12) begin
                    nxt.mon  = 4'd1;
                    nxt.year = (cur.year == 7'd99) ? 7'd0 : cur.year + 7'd1;
                end else begin
                    nxt.mon = cur.mon + 4'd1;
                end
            end else begin
                nxt.date = cur.date + 5'd1;
            end
        end
    end
endmodule

// File: rtl/rtc_encode.sv
module rtc_encode
    import rtc_cal_pkg::*;
(
    input  tm_bin_t  t,
    input  logic     bin_mode,
    input  logic     hr24,
    output fld_vec_t enc
);
    logic [NF-1:0][6:0] val;
    logic               pm;

    always_comb begin
        pm          = (t.hour >= 5'd12);
        val[F_SEC]  = t.sec;
        val[F_MIN]  = t.min;
        if (hr24)
            val[F_HOUR] = 7'(t.hour);
        else if (t.hour == 5'd0 || t.hour == 5'd12)
            val[F_HOUR] = 7'd12;
        else if (pm)
            val[F_HOUR] = 7'(t.hour - 5'd12);
        else
            val[F_HOUR] = 7'(t.hour);
        val[F_DOW]  = 7'(t.dow);
        val[F_DATE] = 7'(t.date);
        val[F_MON]  = 7'(t.mon);
        val[F_YEAR] = t.year;
    end

    for (genvar i = 0; i < NF; i++) begin : g_enc
        fld_t code;
        assign code = bin_mode ? {1'b0, val[i]} : bin_to_bcd(val[i]);
        if (i == int'(F_HOUR)) begin : g_hr
            assign enc[i] = {code[7] | (!hr24 && pm), code[6:0]};
        end else begin : g_oth
            assign enc[i] = code;
        end
    end
endmodule

// File: rtl/rtc_time_engine.sv
module rtc_time_engine
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       set_hold,
    input  logic       bin_mode,
    input  logic       hr24,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_sel,
    output logic [7:0] rd_data,
    output logic       upd_done
);
    localparam logic [SEL_W-1:0] SEL_LIM = SEL_W'(NF);

    fld_vec_t fields_q;
    fld_vec_t fields_nx;
    tm_bin_t  cur_bin;
    tm_bin_t  nxt_bin;

    rtc_decode  u_dec (.raw(fields_q), .bin_mode(bin_mode), .hr24(hr24), .t(cur_bin));
    rtc_advance u_adv (.cur(cur_bin), .nxt(nxt_bin));
    rtc_encode  u_enc (.t(nxt_bin), .bin_mode(bin_mode), .hr24(hr24), .enc(fields_nx));

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= RESET_VAL;
            upd_done <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel < SEL_LIM)
                fields_q[wr_sel] <= wr_data;
            upd_done <= 1'b0;
        end else if (tick && !set_hold) begin
            fields_q <= fields_nx;
            upd_done <= 1'b1;
        end else begin
            upd_done <= 1'b0;
        end
    end

    assign rd_data = (rd_sel < SEL_LIM) ? fields_q[rd_sel] : '0;
endmodule

// File: rtl/rtc_time_engine_chk.sv
module rtc_time_engine_chk
    import rtc_cal_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       set_hold,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic       upd_done,
    input fld_vec_t   fields_q
);
    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (set_hold && !wr_en) |=> ($stable(fields_q) && !upd_done));

    // R10
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !set_hold && !wr_en) |=> upd_done);

    // R10
    done_moves_sec_chk: assert property (@(posedge clk) disable iff (rst)
        upd_done |-> !$stable(fields_q[F_SEC]));

    // R9
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel < 3'd7) |=> (fields_q[$past(wr_sel)] == $past(wr_data)));

    // R11
    write_blocks_done_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !upd_done);

    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(fields_q));
endmodule

bind rtc_time_engine rtc_time_engine_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .set_hold(set_hold), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .upd_done(upd_done), .fields_q(fields_q)
);

// File: tb/rtc_time_engine_test.sv
module rtc_time_engine_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, set_hold = 1'b0, bin_mode = 1'b1, hr24 = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0, rd_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       upd_done;

    int errs = 0, checks = 0;
    logic [7:0] exp_f [7];

    rtc_time_engine uut (.*);

    always #2 clk = ~clk;

    initial begin
        #(4 * 150000);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_byte(input int idx, output logic [7:0] v);
        rd_sel = 3'(idx);
        #1;
        v = rd_data;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        for (int i = 0; i < 7; i++) begin
            read_byte(i, v);
            chk($sformatf("%s byte%0d", tag, i), v, exp_f[i]);
        end
    endtask

    function automatic int ev(input int v);
        return bin_mode ? v : ((v / 10) * 16 + v % 10);
    endfunction

    function automatic int dv(input int b);
        return bin_mode ? (b & 8'h7f) : ((b >> 4) * 10 + (b & 15));
    endfunction

    function automatic int enc_hour(input int h);
        int v;
        if (hr24) return ev(h);
        v = h % 12;
        if (v == 0) v = 12;
        return ev(v) | ((h >= 12) ? 8'h80 : 0);
    endfunction

    function automatic int dec_hour(input int b);
        if (hr24) return dv(b);
        return (dv(b & 8'h7f) % 12) + (((b & 8'h80) != 0) ? 12 : 0);
    endfunction

    function automatic int mdays(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick();
        int s, m, h, dw, d, mo, y;
        s = dv(exp_f[0]); m = dv(exp_f[1]); h = dec_hour(exp_f[2]);
        dw = dv(exp_f[3]); d = dv(exp_f[4]); mo = dv(exp_f[5]); y = dv(exp_f[6]);
        s++;
        if (s == 60) begin s = 0; m++; end
        if (m == 60) begin m = 0; h++; end
        if (h == 24) begin
            h = 0;
            dw = (dw % 7) + 1;
            d++;
            if (d > mdays(mo, y)) begin d = 1; mo++; end
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
        end
        exp_f[0] = 8'(ev(s)); exp_f[1] = 8'(ev(m)); exp_f[2] = 8'(enc_hour(h));
        exp_f[3] = 8'(ev(dw)); exp_f[4] = 8'(ev(d)); exp_f[5] = 8'(ev(mo)); exp_f[6] = 8'(ev(y));
    endtask

    task automatic wr(input int idx, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(idx); wr_data = 8'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int s, input int m, input int h, input int dw,
                        input int d, input int mo, input int y);
        @(negedge clk);
        set_hold = 1'b1;
        exp_f[0] = 8'(ev(s)); exp_f[1] = 8'(ev(m)); exp_f[2] = 8'(enc_hour(h));
        exp_f[3] = 8'(ev(dw)); exp_f[4] = 8'(ev(d)); exp_f[5] = 8'(ev(mo)); exp_f[6] = 8'(ev(y));
        for (int i = 0; i < 7; i++) wr(i, exp_f[i]);
        set_hold = 1'b0;
    endtask

    task automatic do_tick(input string tag);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
        chk({tag, " done pulse R10"}, upd_done, 1);
        check_all(tag);
        @(negedge clk);
        chk({tag, " done single R10"}, upd_done, 0);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_f = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
        chk("R1 done", upd_done, 0);
        check_all("R1 reset");

        bin_mode = 1'b1; hr24 = 1'b1;
        load(59, 59, 23, 7, 31, 12, 99);
        do_tick("R7 R5 R2 century");
        load(58, 59, 13, 3, 10, 5, 42);
        do_tick("R2 binary");
        do_tick("R2 binary carry");

        bin_mode = 1'b0; hr24 = 1'b1;
        load(9, 0, 0, 1, 1, 1, 0);
        do_tick("R3 bcd digit");
        load(59, 59, 19, 2, 19, 8, 9);
        do_tick("R3 bcd carry");

        hr24 = 1'b0;
        load(59, 59, 11, 1, 5, 6, 30);
        do_tick("R4 noon");
        chk("R4 noon byte", exp_f[2], 8'h92);
        load(59, 59, 12, 1, 5, 6, 30);
        do_tick("R4 one pm");
        load(59, 59, 23, 4, 5, 6, 30);
        do_tick("R4 midnight");
        chk("R4 midnight byte", exp_f[2], 8'h12);

        bin_mode = 1'b1; hr24 = 1'b1;
        load(59, 59, 23, 1, 28, 2, 24);
        do_tick("R6 leap feb28");
        do_tick("R6 leap feb29 no roll");
        load(59, 59, 23, 1, 29, 2, 24);
        do_tick("R6 leap feb29");
        load(59, 59, 23, 1, 28, 2, 23);
        do_tick("R6 common feb");
        load(59, 59, 23, 1, 30, 4, 23);
        do_tick("R6 april");
        load(59, 59, 23, 1, 31, 1, 23);
        do_tick("R6 january");

        // R8 hold freezes ticks
        load(10, 20, 5, 2, 3, 4, 5);
        @(negedge clk);
        set_hold = 1'b1; tick = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R8 no done", upd_done, 0);
        end
        tick = 1'b0; set_hold = 1'b0;
        check_all("R8 frozen");

        // R11 write beats tick
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'd33; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        exp_f[0] = 8'd33;
        chk("R11 no done", upd_done, 0);
        check_all("R11 write wins");

        // R9 index 7
        wr(7, 8'h5a);
        read_byte(7, v);
        chk("R9 sel7 read", v, 0);
        check_all("R9 sel7 write ignored");

        // R12 mode switch keeps bytes
        @(negedge clk);
        bin_mode = 1'b0; hr24 = 1'b0;
        @(negedge clk);
        check_all("R12 no conversion");

        // random
        for (int n = 0; n < 300; n++) begin
            int s, m, h, dw, d, mo, y;
            string tag;
            bin_mode = 1'($urandom_range(0, 1));
            hr24     = 1'($urandom_range(0, 1));
            mo = $urandom_range(1, 12);
            y  = $urandom_range(0, 99);
            d  = ($urandom_range(0, 2) == 0) ? mdays(mo, y) : $urandom_range(1, mdays(mo, y));
            dw = $urandom_range(1, 7);
            h  = ($urandom_range(0, 2) == 0) ? 23 : $urandom_range(0, 23);
            m  = ($urandom_range(0, 1) == 0) ? 59 : $urandom_range(0, 59);
            s  = ($urandom_range(0, 1) == 0) ? 59 : $urandom_range(0, 59);
            load(s, m, h, dw, d, mo, y);
            tag = bin_mode ? "R2 rand" : "R3 rand";
            if (!hr24) tag = {tag, " R4"};
            do_tick(tag);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule